// File: doc/BRIEF.md
# SPI Master with State-Tracked Status

This block is an SPI master whose behaviour is governed by a five-state control machine: reset, sleep, setup, busy and error. A host talks to it over a small register port. The port has a control register, a data register and a status register. The control register holds an enable bit, an interrupt-enable bit and a serial clock divider. The data register starts a transfer when written and returns the last received byte when read. The status register reports the enabled, busy and error flags and a sticky interrupt flag. Each state fixes its own combination of these flags.

Writing the data register in setup starts one 8-bit full-duplex exchange in SPI mode 0, MSB first. For every bit driven on the serial data output, one bit is sampled from the serial data input. A normal end returns the block to setup, stores the received byte and raises the interrupt flag. A write to the data or control register during a transfer is prohibited. Such a write aborts the transfer and parks the block in error, and only a control write that clears the enable bit leaves that state.

Top module: `spi_status_master`

## Requirements
- R1: While `rst_n` is low the block is held in its reset state, with status flags all 0, `spi_sclk` low and `spi_cs_n` high, independent of the clock. One clock after release it is in sleep, with the status register reading 0.
- R2: In sleep, a control write (address 0) with bit 0 = 1 moves the block to setup. The status register (address 2) then reads 0x01: bit 0 enabled = 1, bit 1 busy = 0, bit 2 error = 0.
- R3: In setup, a write to the data register (address 1) moves the block to busy. Status then reads 0x03 and `spi_cs_n` is low.
- R4: A transfer is 8 bits, MSB first, in SPI mode 0. `spi_sclk` idles low, `spi_mosi` is stable at every rising edge, and `spi_miso` is sampled on the rising edges. Each `spi_sclk` half period lasts N+1 clocks, with N = control bits [7:2].
- R5: When a transfer ends normally the block returns to setup. Reading the data register returns the byte sampled from `spi_miso`, and status bit 3 (interrupt flag) is set.
- R6: Any write to the data or control register while busy moves the block to error. Status then reads 0x05, `spi_sclk` is low, `spi_cs_n` is high, and the stored receive byte is unchanged.
- R7: In error, data writes and control writes with bit 0 = 1 leave the block in error. A control write with bit 0 = 0 moves it to sleep, and so does the same write in setup.
- R8: The interrupt flag stays set until status bit 3 is written with 1. The `irq` output is the flag ANDed with control bit 1.
- R9: If a prohibited write lands in the same cycle as the final serial clock fall, error wins. The interrupt flag stays 0 and the receive byte is not updated.
- R10: A data write in sleep is ignored: status stays 0 and no serial clock or chip select activity occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 data, 2 status |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| irq | output | 1 | Interrupt flag gated by interrupt enable |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Chip select, low while busy |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
The normal end of a transfer and a prohibited register write can fall into the same clock cycle, and the two would send the block to opposite states. The bench sets the divider to its smallest value so that every clock is a serial edge. It counts rising serial clock edges and drives a data-register write exactly on the edge that carries the eighth falling edge. It then judges the result by the status reading 0x05 with the interrupt flag clear, and by the data register still holding the byte from the previous transfer.

// File: rtl/spi_status_pkg.sv
package spi_status_pkg;

    typedef enum logic [2:0] {
        ST_RESET = 3'd0,
        ST_SLEEP = 3'd1,
        ST_SETUP = 3'd2,
        ST_BUSY  = 3'd3,
        ST_ERROR = 3'd4
    } spi_state_e;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_DATA = 2'd1;
    localparam logic [1:0] ADDR_STAT = 2'd2;

endpackage

// File: rtl/spi_mode_fsm.sv
module spi_mode_fsm
    import spi_status_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_ctrl,
    input  logic       wr_data,
    input  logic       en_bit,
    input  logic       done,
    output spi_state_e state,
    output logic       start,
    output logic       abort,
    output logic       reinit
);

    spi_state_e st_d, st_q;

    always_comb begin
        st_d  = st_q;
        start = 1'b0;
        abort = 1'b0;
        case (st_q)
            ST_RESET: st_d = ST_SLEEP;
            ST_SLEEP: begin
                if (wr_ctrl && en_bit) st_d = ST_SETUP;
            end
            ST_SETUP: begin
                if (wr_ctrl && !en_bit) begin
                    st_d = ST_SLEEP;
                end else if (wr_data) begin
                    st_d  = ST_BUSY;
                    start = 1'b1;
                end
            end
            ST_BUSY: begin
                // a prohibited access outranks a normal end in the same cycle
                if (wr_ctrl || wr_data) begin
                    st_d  = ST_ERROR;
                    abort = 1'b1;
                end else if (done) begin
                    st_d = ST_SETUP;
                end
            end
            ST_ERROR: begin
                if (wr_ctrl && !en_bit) st_d = ST_SLEEP;
            end
            default: st_d = ST_SLEEP;
        endcase
        reinit = ((st_d == ST_SETUP) && (st_q != ST_SETUP)) ||
                 ((st_q == ST_ERROR) && (st_d != ST_ERROR));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RESET;
        else        st_q <= st_d;
    end

    assign state = st_q;

endmodule

// File: rtl/spi_half_tick.sv
module spi_half_tick #(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clear,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick = run && (cnt_q == div);
        if (!run || clear || tick) cnt_d = '0;
        else                       cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/spi_bit_engine.sv
module spi_bit_engine #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tick,
    input  logic              start,
    input  logic              clear,
    input  logic [DATA_W-1:0] tx_in,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic [DATA_W-1:0] rx,
    output logic              done
);

    localparam int BIT_W = $clog2(DATA_W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

    typedef struct packed {
        logic [DATA_W-1:0] tx;
        logic [DATA_W-1:0] rx;
        logic [BIT_W-1:0]  bitcnt;
        logic              sclk;
    } eng_t;

    eng_t e_d, e_q;

    always_comb begin
        done = run && tick && e_q.sclk && (e_q.bitcnt == LAST_BIT);
        e_d  = e_q;
        if (clear) begin
            e_d = '0;
        end else if (start) begin
            e_d    = '0;
            e_d.tx = tx_in;
        end else if (run && tick) begin
            if (!e_q.sclk) begin
                e_d.sclk = 1'b1;
                e_d.rx   = {e_q.rx[DATA_W-2:0], miso};
            end else begin
                e_d.sclk = 1'b0;
                if (e_q.bitcnt != LAST_BIT) begin
                    e_d.tx     = {e_q.tx[DATA_W-2:0], 1'b0};
                    e_d.bitcnt = e_q.bitcnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= '0;
        else        e_q <= e_d;
    end

    assign sclk = e_q.sclk;
    assign mosi = run && e_q.tx[DATA_W-1];
    assign rx   = e_q.rx;

endmodule

// File: rtl/spi_status_master.sv
module spi_status_master
    import spi_status_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq,
    output logic              spi_sclk,
    output logic              spi_cs_n,
    output logic              spi_mosi,
    input  logic              spi_miso
);

    localparam int DIV_W = DATA_W - 2;

    typedef struct packed {
        logic              irq_en;
        logic [DIV_W-1:0]  div;
        logic [DATA_W-1:0] rx;
        logic              irq_flag;
    } regs_t;

    regs_t regs_d, regs_q;

    spi_state_e        cur_state;
    logic              wr_ctrl, wr_data, wr_stat;
    logic              start, abort, reinit, done, tick, run;
    logic              flag_en, flag_busy, flag_err, irq_flag;
    logic [DATA_W-1:0] eng_rx;

    assign wr_ctrl = reg_wr && (reg_addr == ADDR_CTRL);
    assign wr_data = reg_wr && (reg_addr == ADDR_DATA);
    assign wr_stat = reg_wr && (reg_addr == ADDR_STAT);

    spi_mode_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ctrl (wr_ctrl),
        .wr_data (wr_data),
        .en_bit  (reg_wdata[0]),
        .done    (done),
        .state   (cur_state),
        .start   (start),
        .abort   (abort),
        .reinit  (reinit)
    );

    assign run = (cur_state == ST_BUSY);

    spi_half_tick #(.DIV_W(DIV_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .clear (abort || reinit),
        .div   (regs_q.div),
        .tick  (tick)
    );

    spi_bit_engine #(.DATA_W(DATA_W)) u_eng (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick),
        .start (start),
        .clear (abort || reinit),
        .tx_in (reg_wdata),
        .miso  (spi_miso),
        .sclk  (spi_sclk),
        .mosi  (spi_mosi),
        .rx    (eng_rx),
        .done  (done)
    );

    always_comb begin
        regs_d = regs_q;
        if (wr_ctrl && !abort) begin
            regs_d.irq_en = reg_wdata[1];
            regs_d.div    = reg_wdata[DATA_W-1:2];
        end
        if (wr_stat && reg_wdata[3]) regs_d.irq_flag = 1'b0;
        if (done && !abort) begin
            regs_d.rx       = eng_rx;
            regs_d.irq_flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign flag_en   = (cur_state == ST_SETUP) || (cur_state == ST_BUSY) ||
                       (cur_state == ST_ERROR);
    assign flag_busy = (cur_state == ST_BUSY);
    assign flag_err  = (cur_state == ST_ERROR);
    assign irq_flag  = regs_q.irq_flag;

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_CTRL: reg_rdata = {regs_q.div, regs_q.irq_en, flag_en};
            ADDR_DATA: reg_rdata = regs_q.rx;
            ADDR_STAT: reg_rdata[3:0] = {irq_flag, flag_err, flag_busy, flag_en};
            default:   reg_rdata = '0;
        endcase
    end

    assign irq      = irq_flag && regs_q.irq_en;
    assign spi_cs_n = !flag_busy;

endmodule

// File: rtl/spi_status_master_chk.sv
module spi_status_master_chk
    import spi_status_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input spi_state_e st,
    input logic       wr_ctrl,
    input logic       wr_data,
    input logic       en_bit,
    input logic       sclk,
    input logic       irq_flag
);

    AST_RESET_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_RESET |=> st == ST_SLEEP);                               // R1
    AST_SLEEP_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SLEEP && wr_ctrl && en_bit) |=> st == ST_SETUP);        // R2
    AST_SETUP_START: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SETUP && wr_data && !wr_ctrl) |=> st == ST_BUSY);      // R3
    AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        st != ST_BUSY |-> !sclk);                                          // R4
    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flag) |-> $past(st) == ST_BUSY);                        // R5
    AST_BUSY_VIOLATION: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_BUSY && (wr_ctrl || wr_data)) |=> st == ST_ERROR);      // R6
    AST_ERROR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ERROR && !(wr_ctrl && !en_bit)) |=> st == ST_ERROR);    // R7
    AST_ERROR_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ERROR && wr_ctrl && !en_bit) |=> st == ST_SLEEP);       // R7
    AST_SLEEP_DATA_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SLEEP && !wr_ctrl) |=> st == ST_SLEEP);                 // R10

endmodule

bind spi_status_master spi_status_master_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .st       (cur_state),
    .wr_ctrl  (wr_ctrl),
    .wr_data  (wr_data),
    .en_bit   (reg_wdata[0]),
    .sclk     (spi_sclk),
    .irq_flag (irq_flag)
);

// File: tb/spi_status_master_test.sv
`timescale 1ns/1ps
module spi_status_master_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd2;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq, spi_sclk, spi_cs_n, spi_mosi, spi_miso;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [7:0] slave_byte = 8'h00;
    int         slave_idx = 0;
    logic [7:0] mosi_cap = 8'h00;
    int         rises = 0;
    int         hi_cnt = 0;
    logic [7:0] last_rx = 8'h00;

    always #2.5 clk = ~clk;

    spi_status_master uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso)
    );

    // slave model: presents MSB first, advances on falling serial edges
    assign spi_miso = (slave_idx < 8) ? slave_byte[7 - slave_idx] : 1'b0;
    always @(negedge spi_sclk) slave_idx = slave_idx + 1;
    always @(posedge spi_sclk) begin
        mosi_cap = {mosi_cap[6:0], spi_mosi};
        rises = rises + 1;
    end
    always @(negedge clk) if (spi_sclk) hi_cnt = hi_cnt + 1;

    localparam logic [7:0] V_CTRL [5] = '{8'h03, 8'h05, 8'h0B, 8'h0F, 8'h15};
    localparam logic [7:0] V_TX   [5] = '{8'hA5, 8'hFF, 8'h00, 8'h81, 8'h5A};
    localparam logic [7:0] V_SLV  [5] = '{8'h3C, 8'h00, 8'hFF, 8'h7E, 8'hC3};

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #0.5 d = reg_rdata;
    endtask

    task automatic rd_chk(input logic [1:0] a, input logic [7:0] exp, input string req);
        logic [7:0] v;
        rd(a, v);
        check(v == exp, req, v, exp);
    endtask

    task automatic arm(input logic [7:0] slv);
        slave_byte = slv; slave_idx = 0; rises = 0; hi_cnt = 0; mosi_cap = 8'h00;
    endtask

    task automatic wait_idle(input string req);
        logic [7:0] v;
        int n = 0;
        v = 8'h02;
        while (v[1] && n < 3000) begin
            rd(2'd2, v);
            n++;
        end
        check(n < 3000, req, n, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        // R1: reset holds everything quiet
        #12;
        #0.5 check({reg_rdata[3:0], spi_sclk, spi_cs_n} == 6'b000001, "R1 in reset",
                   {reg_rdata[3:0], spi_sclk, spi_cs_n}, 6'b000001);
        @(negedge clk); rst_n = 1'b1;
        repeat (2) @(negedge clk);
        rd_chk(2'd2, 8'h00, "R1 sleep after release");

        // R10: data write in sleep ignored
        arm(8'h00);
        wr(2'd1, 8'h99);
        rd_chk(2'd2, 8'h00, "R10 status after sleep data write");
        check(spi_cs_n && rises == 0, "R10 no serial activity", rises, 0);

        // R2
        wr(2'd0, 8'h01);
        rd_chk(2'd2, 8'h01, "R2 setup status");

        // table of transfers: R3 R4 R5 R8
        for (int i = 0; i < 5; i++) begin
            wr(2'd0, V_CTRL[i]);
            arm(V_SLV[i]);
            wr(2'd1, V_TX[i]);
            rd_chk(2'd2, 8'h03, "R3 busy status");
            check(!spi_cs_n, "R3 chip select low", spi_cs_n, 0);
            wait_idle("R5 transfer ends");
            check(mosi_cap == V_TX[i], "R4 mosi bits", mosi_cap, V_TX[i]);
            check(hi_cnt == 8 * (int'(V_CTRL[i][7:2]) + 1), "R4 sclk high time",
                  hi_cnt, 8 * (int'(V_CTRL[i][7:2]) + 1));
            rd_chk(2'd2, 8'h09, "R5 setup with irq flag");
            rd_chk(2'd1, V_SLV[i], "R5 received byte");
            check(irq == V_CTRL[i][1], "R8 irq gated by enable", irq, V_CTRL[i][1]);
            wr(2'd2, 8'h08);
            rd_chk(2'd2, 8'h01, "R8 flag cleared");
            check(!irq, "R8 irq low after clear", irq, 0);
            last_rx = V_SLV[i];
        end

        // R8: flag sticky while not cleared (write 0 to bit 3)
        wr(2'd0, 8'h03);
        arm(8'h12);
        wr(2'd1, 8'h34);
        wait_idle("R8 transfer ends");
        wr(2'd2, 8'h00);
        rd_chk(2'd2, 8'h09, "R8 flag sticky");
        wr(2'd2, 8'h08);
        last_rx = 8'h12;

        // R6: data write during busy
        wr(2'd0, 8'h0D);
        arm(8'hEE);
        wr(2'd1, 8'h77);
        repeat (5) @(negedge clk);
        wr(2'd1, 8'h66);
        rd_chk(2'd2, 8'h05, "R6 error status");
        check(spi_cs_n && !spi_sclk, "R6 lines idle in error", {spi_cs_n, spi_sclk}, 2'b10);
        rd_chk(2'd1, last_rx, "R6 rx unchanged");

        // R7: error exits only through enable clear
        wr(2'd1, 8'hAA);
        rd_chk(2'd2, 8'h05, "R7 data write in error");
        wr(2'd0, 8'h0D);
        rd_chk(2'd2, 8'h05, "R7 enable write in error");
        wr(2'd0, 8'h00);
        rd_chk(2'd2, 8'h00, "R7 error to sleep");

        // R6: control write during busy
        wr(2'd0, 8'h0D);
        wr(2'd1, 8'h55);
        wr(2'd0, 8'h0D);
        rd_chk(2'd2, 8'h05, "R6 control write in busy");
        wr(2'd0, 8'h00);

        // R7: setup to sleep
        wr(2'd0, 8'h01);
        wr(2'd0, 8'h00);
        rd_chk(2'd2, 8'h00, "R7 setup to sleep");

        // R9: prohibited write on the completing edge
        wr(2'd0, 8'h03);
        arm(8'h5F);
        wr(2'd1, 8'hC6);
        begin
            int n = 0;
            while (!(rises == 8 && spi_sclk) && n < 200) begin
                @(negedge clk);
                n++;
            end
        end
        reg_addr = 2'd1; reg_wdata = 8'h11; reg_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
        rd_chk(2'd2, 8'h05, "R9 error wins over end");
        check(!irq, "R9 no irq", irq, 0);
        rd_chk(2'd1, last_rx, "R9 rx not updated");
        wr(2'd0, 8'h00);

        // R1: asynchronous reset in the middle of a transfer
        wr(2'd0, 8'h0D);
        wr(2'd1, 8'hF0);
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b0;
        reg_addr = 2'd2;
        #0.5 check({reg_rdata[3:0], spi_cs_n} == 5'b00001, "R1 async reset",
                   {reg_rdata[3:0], spi_cs_n}, 5'b00001);
        @(negedge clk); rst_n = 1'b1;
        rd_chk(2'd2, 8'h00, "R1 sleep after second release");

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule